// File: doc/BRIEF.md
# ATA Task File Register Block

This block is the register side of a single ATA disk device. A host reaches it through an eight-location I/O window with 16-bit data. The window holds the data port, a feature byte, a sector count, three LBA address bytes and the device/head byte. One further location reads as status and writes as command. The block decodes four commands: IDENTIFY DEVICE, FLUSH CACHE, READ DMA and WRITE DMA. For each one it steps the status bits through their phases and raises an interrupt request.

IDENTIFY is served inside the block. The 256 identify words are computed from the word index, so no buffer is stored. The serial and firmware strings are parameters. FLUSH CACHE and the two DMA commands are handed to outside logic: the block issues a one-cycle start pulse together with a transfer kind and the captured address and count. It then stays busy until a completion pulse returns. The storage medium, the DMA engine and cable timing lie outside this block.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, status reads 0x40 (DRDY set, BSY, DF, DRQ and ERR clear), and irq and cmd_start are low.
- R2: Offsets 1 to 6 hold feature, sector count, LBA low, LBA mid, LBA high and device bytes, which read back in bits 7:0 with bits 15:8 zero. cmd_count, cmd_lba ({high, mid, low}) show them live. Device bit 4 appears on cmd_dev and bit 6 appears on cmd_lba_mode.
- R3: While BSY is set, writes to offsets 1 to 6 leave the stored bytes unchanged. A command written while BSY or DRQ is set is ignored.
- R4: Command 0xEC sets DRQ and raises irq. Status reads 0x48 before each of the 256 data-word reads at offset 0. After the last word it reads 0x40.
- R5: Identify words 10 to 19 carry the serial string and words 23 to 26 carry the firmware string, with the first character of each pair in bits 15:8. Word 85 has bit 5 set. All other words read 0.
- R6: Command 0xE7 gives status 0xC0 and a one-cycle cmd_start with cmd_kind 1. Status stays 0xC0 until an ext_done pulse. That pulse leaves status at 0x40 and raises irq.
- R7: Commands 0xC8 and 0xCA give status 0xC0 and cmd_start with cmd_kind 2 and 3 respectively, with cmd_lba and cmd_count equal to the programmed bytes. ext_done ends the command as in R6.
- R8: Any other command code leaves status 0x41 and raises irq. The next accepted command clears ERR.
- R9: A status read (offset 7) drops irq on the following edge. If a completion falls in that same cycle, irq stays high.
- R10: While irq_disable is high, completions do not raise irq, and the status bits still follow R4 to R8.
- R11: ext_done while the block is not busy changes neither status nor irq.
- R12: A data read while DRQ is clear returns 0 and does not alter status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; read side effects act at its edge |
| bus_wdata | input | 16 | Write data (bytes use bits 7:0) |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| ext_done | input | 1 | Completion pulse from the flush/DMA logic |
| irq_disable | input | 1 | Interrupt mask held by host control logic |
| irq | output | 1 | Interrupt request |
| cmd_start | output | 1 | One-cycle pulse when a flush or DMA command is accepted |
| cmd_kind | output | 2 | 1 flush, 2 read DMA, 3 write DMA |
| cmd_lba | output | 24 | LBA from the three address bytes |
| cmd_count | output | 8 | Sector count byte |
| cmd_dev | output | 1 | Device select bit |
| cmd_lba_mode | output | 1 | LBA addressing bit |

## Verification
Two events can fall on the same edge: the host reads status, which clears irq, and the external logic reports completion, which raises it. The bench forces this by asserting the status read strobe and ext_done in one cycle while a flush is busy. It checks that the read still returns the busy status 0xC0 and that irq is high after the edge. A later status read must then clear irq. Random DMA rounds also send completions at random delays between status polls, and these rounds toggle the interrupt mask.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
   localparam int ST_BSY  = 7;
   localparam int ST_DRDY = 6;
   localparam int ST_DF   = 5;
   localparam int ST_DRQ  = 3;
   localparam int ST_ERR  = 0;

   localparam int DEVB_SEL = 4;
   localparam int DEVB_LBA = 6;

   localparam logic [7:0] OP_RD_DMA   = 8'hC8;
   localparam logic [7:0] OP_WR_DMA   = 8'hCA;
   localparam logic [7:0] OP_FLUSH    = 8'hE7;
   localparam logic [7:0] OP_IDENTIFY = 8'hEC;

   typedef enum logic [1:0] {
      XK_NONE  = 2'd0,
      XK_FLUSH = 2'd1,
      XK_READ  = 2'd2,
      XK_WRITE = 2'd3
   } xfer_kind_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_PIO,
      PH_WAIT
   } phase_t;
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs #(
   parameter int ADDR_W = 3,
   parameter int BYTE_W = 8,
   localparam int NUM_TF = (1 << ADDR_W) - 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     lock,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [BYTE_W-1:0]        wdata,
   output logic [NUM_TF*BYTE_W-1:0] tf_flat
);
   if (ADDR_W != 3) begin : g_bad_addr
      $error("ata_tf_regs: window must span eight offsets");
   end

   for (genvar g = 0; g < NUM_TF; g++) begin : g_tf
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && !lock && addr == ADDR_W'(g + 1))
            q <= wdata;
      end
      assign tf_flat[g*BYTE_W +: BYTE_W] = q;
   end

   AST_TF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lock) |=> $stable(tf_flat)) else $error("locked write changed task file"); // R3
endmodule

// File: rtl/ata_tf_ident.sv
module ata_tf_ident #(
   parameter int WORDS        = 256,
   parameter int SERIAL_CHARS = 20,
   parameter int FW_CHARS     = 8,
   parameter int SERIAL_BASE  = 10,
   parameter int FW_BASE      = 23,
   parameter int CAP_WORD     = 85,
   parameter int CAP_BIT      = 5,
   parameter logic [8*SERIAL_CHARS-1:0] SERIAL_STR = '0,
   parameter logic [8*FW_CHARS-1:0]     FW_STR     = '0,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic [IDX_W-1:0] idx,
   output logic [15:0]      word
);
   localparam int SER_WORDS = SERIAL_CHARS / 2;
   localparam int FW_WORDS  = FW_CHARS / 2;

   if ((SERIAL_CHARS % 2) != 0 || (FW_CHARS % 2) != 0) begin : g_bad_len
      $error("ata_tf_ident: string lengths must be even");
   end
   if (SERIAL_BASE + SER_WORDS > WORDS || FW_BASE + FW_WORDS > WORDS || CAP_WORD >= WORDS) begin : g_bad_map
      $error("ata_tf_ident: field beyond identify page");
   end

   always_comb begin
      word = '0;
      for (int k = 0; k < SER_WORDS; k++)
         if (int'(idx) == SERIAL_BASE + k)
            word = SERIAL_STR[8*SERIAL_CHARS-1-16*k -: 16];
      for (int k = 0; k < FW_WORDS; k++)
         if (int'(idx) == FW_BASE + k)
            word = FW_STR[8*FW_CHARS-1-16*k -: 16];
      if (int'(idx) == CAP_WORD)
         word[CAP_BIT] = 1'b1;
   end
endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
   import ata_tf_pkg::*;
#(
   parameter int WORDS = 256,
   localparam int IDX_W = $clog2(WORDS),
   localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [7:0]       cmd_code,
   input  logic             data_re,
   input  logic             stat_re,
   input  logic             ext_done,
   input  logic             irq_disable,
   output logic             bsy,
   output logic             drq,
   output logic             err,
   output logic [IDX_W-1:0] idx,
   output logic             irq,
   output logic             cmd_start,
   output xfer_kind_t       cmd_kind
);
   phase_t phase;
   logic   accept, known, raise;

   always_comb begin
      accept = cmd_we && !bsy && !drq;
      known  = (cmd_code == OP_IDENTIFY) || (cmd_code == OP_FLUSH) ||
               (cmd_code == OP_RD_DMA)   || (cmd_code == OP_WR_DMA);
      raise  = (accept && (cmd_code == OP_IDENTIFY || !known)) ||
               (phase == PH_WAIT && ext_done);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         bsy       <= 1'b0;
         drq       <= 1'b0;
         err       <= 1'b0;
         idx       <= '0;
         irq       <= 1'b0;
         cmd_start <= 1'b0;
         cmd_kind  <= XK_NONE;
      end else begin
         cmd_start <= 1'b0;
         if (raise && !irq_disable) irq <= 1'b1;
         else if (stat_re)          irq <= 1'b0;
         unique case (phase)
            PH_IDLE: if (accept) begin
               err <= !known;
               unique case (cmd_code)
                  OP_IDENTIFY: begin drq <= 1'b1; idx <= '0; phase <= PH_PIO; end
                  OP_FLUSH:  begin bsy <= 1'b1; cmd_start <= 1'b1; cmd_kind <= XK_FLUSH; phase <= PH_WAIT; end
                  OP_RD_DMA: begin bsy <= 1'b1; cmd_start <= 1'b1; cmd_kind <= XK_READ;  phase <= PH_WAIT; end
                  OP_WR_DMA: begin bsy <= 1'b1; cmd_start <= 1'b1; cmd_kind <= XK_WRITE; phase <= PH_WAIT; end
                  default: ;
               endcase
            end
            PH_PIO: if (data_re) begin
               idx <= idx + 1'b1;
               if (idx == LAST) begin
                  drq   <= 1'b0;
                  phase <= PH_IDLE;
               end
            end
            PH_WAIT: if (ext_done) begin
               bsy   <= 1'b0;
               phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   AST_BSY_NOT_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
      !(bsy && drq)) else $error("BSY and DRQ together"); // R6
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> bsy) else $error("start without BSY"); // R7
   AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!bsy && !drq)) else $error("ERR during active phase"); // R8
   AST_DRQ_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (drq && data_re && idx == LAST) |=> !drq) else $error("DRQ held after last word"); // R4
   AST_IRQ_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_re && !raise) |=> !irq) else $error("irq survived status read"); // R9
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_disable && !irq) |=> !irq) else $error("irq rose while masked"); // R10
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bsy && ext_done && !cmd_we) |=> !bsy) else $error("idle done changed BSY"); // R11
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
   import ata_tf_pkg::*;
#(
   parameter int IDENT_WORDS  = 256,
   parameter int SERIAL_CHARS = 20,
   parameter int FW_CHARS     = 8,
   parameter logic [8*SERIAL_CHARS-1:0] SERIAL_STR = "testdisk            ",
   parameter logic [8*FW_CHARS-1:0]     FW_STR     = "version "
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  bus_addr,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   input  logic        ext_done,
   input  logic        irq_disable,
   output logic        irq,
   output logic        cmd_start,
   output logic [1:0]  cmd_kind,
   output logic [23:0] cmd_lba,
   output logic [7:0]  cmd_count,
   output logic        cmd_dev,
   output logic        cmd_lba_mode
);
   localparam int ADDR_W = 3;
   localparam int NUM_TF = (1 << ADDR_W) - 2;
   localparam int IDX_W  = $clog2(IDENT_WORDS);
   localparam logic [ADDR_W-1:0] A_DATA = '0;
   localparam logic [ADDR_W-1:0] A_STAT = '1;

   if (IDENT_WORDS != 256) begin : g_bad_words
      $error("ata_taskfile: identify page is 256 words");
   end

   logic [NUM_TF*8-1:0] tf_flat;
   logic                bsy, drq, err;
   logic [IDX_W-1:0]    idx;
   logic [15:0]         id_word;
   logic [7:0]          status;
   xfer_kind_t          kind;

   ata_tf_regs #(.ADDR_W(ADDR_W), .BYTE_W(8)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .lock(bsy),
      .addr(bus_addr), .wdata(bus_wdata[7:0]), .tf_flat(tf_flat));

   ata_tf_ident #(
      .WORDS(IDENT_WORDS), .SERIAL_CHARS(SERIAL_CHARS), .FW_CHARS(FW_CHARS),
      .SERIAL_STR(SERIAL_STR), .FW_STR(FW_STR)) i_ident (
      .idx(idx), .word(id_word));

   ata_tf_ctrl #(.WORDS(IDENT_WORDS)) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cmd_we(bus_wr && bus_addr == A_STAT), .cmd_code(bus_wdata[7:0]),
      .data_re(bus_rd && bus_addr == A_DATA), .stat_re(bus_rd && bus_addr == A_STAT),
      .ext_done(ext_done), .irq_disable(irq_disable),
      .bsy(bsy), .drq(drq), .err(err), .idx(idx), .irq(irq),
      .cmd_start(cmd_start), .cmd_kind(kind));

   always_comb begin
      status          = '0;
      status[ST_BSY]  = bsy;
      status[ST_DRDY] = 1'b1;
      status[ST_DF]   = 1'b0;
      status[ST_DRQ]  = drq;
      status[ST_ERR]  = err;
      unique case (bus_addr)
         A_DATA:  bus_rdata = drq ? id_word : 16'h0000;
         A_STAT:  bus_rdata = {8'h00, status};
         default: bus_rdata = {8'h00, tf_flat[8*(int'(bus_addr)-1) +: 8]};
      endcase
   end

   assign cmd_kind     = kind;
   assign cmd_count    = tf_flat[8*1 +: 8];
   assign cmd_lba      = {tf_flat[8*4 +: 8], tf_flat[8*3 +: 8], tf_flat[8*2 +: 8]};
   assign cmd_dev      = tf_flat[8*5 + DEVB_SEL];
   assign cmd_lba_mode = tf_flat[8*5 + DEVB_LBA];

   AST_DF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_STAT) |-> !bus_rdata[ST_DF]) else $error("DF reported"); // R1
endmodule

// File: tb/test_ata_taskfile.sv
module test_ata_taskfile;
   logic        clk = 0, rst_n = 0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 0, bus_rd = 0, ext_done = 0, irq_disable = 0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic        irq, cmd_start, cmd_dev, cmd_lba_mode;
   logic [1:0]  cmd_kind;
   logic [23:0] cmd_lba;
   logic [7:0]  cmd_count;

   int n_tests = 0, n_fail = 0;
   bit done = 0;
   logic [7:0] tf [1:6];
   string ser = "testdisk            ";
   string fw  = "version ";

   always #5 clk = ~clk;

   ata_taskfile i_ata_taskfile (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = {8'h00, d}; bus_wr = 1;
      @(posedge clk); #1 bus_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
      @(posedge clk); #1 bus_rd = 0;
   endtask

   task automatic done_pulse();
      @(negedge clk); ext_done = 1;
      @(posedge clk); #1 ext_done = 0;
   endtask

   function automatic logic [15:0] id_exp(input int w);
      if (w >= 10 && w < 20) return {ser[2*(w-10)], ser[2*(w-10)+1]};
      if (w >= 23 && w < 27) return {fw[2*(w-23)], fw[2*(w-23)+1]};
      if (w == 85) return 16'h0020;
      return 16'h0000;
   endfunction

   task automatic check_tf(input string req);
      logic [15:0] d;
      for (int a = 1; a <= 6; a++) begin
         rd(3'(a), d);
         chk(req, d, {8'h00, tf[a]});
      end
      chk(req, cmd_lba, {tf[5], tf[4], tf[3]});
      chk(req, cmd_count, tf[2]);
      chk(req, cmd_dev, tf[6][4]);
      chk(req, cmd_lba_mode, tf[6][6]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      int unsigned seed;
      seed = $urandom(32'd20240611);
      for (int a = 1; a <= 6; a++) tf[a] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      #1 chk("R1 irq", irq, 0);
      chk("R1 start", cmd_start, 0);
      rd(3'd7, d); chk("R1 status", d, 16'h0040);

      // R2 random task-file programming
      for (int i = 0; i < 24; i++) begin
         int a = 1 + ($urandom % 6);
         logic [7:0] v = 8'($urandom);
         wr(3'(a), v); tf[a] = v;
      end
      check_tf("R2");

      // R4/R5 identify
      wr(3'd6, 8'h00); tf[6] = 8'h00;
      wr(3'd7, 8'hEC);
      chk("R4 irq on DRQ", irq, 1);
      for (int w = 0; w < 256; w++) begin
         rd(3'd7, d); chk("R4 status per word", d, 16'h0048);
         if (w == 0) chk("R9 irq cleared", irq, 0);
         rd(3'd0, d); chk("R5 word", d, id_exp(w));
      end
      rd(3'd7, d); chk("R4 after last", d, 16'h0040);
      // R12 data read with DRQ clear
      rd(3'd0, d); chk("R12 data", d, 16'h0000);
      rd(3'd7, d); chk("R12 status", d, 16'h0040);

      // R6 flush with delayed completion, R3 locking while busy
      wr(3'd7, 8'hE7);
      chk("R6 start", cmd_start, 1);
      chk("R6 kind", cmd_kind, 2'd1);
      repeat (1 + $urandom % 20) @(negedge clk);
      rd(3'd7, d); chk("R6 busy", d, 16'h00C0);
      chk("R6 no irq", irq, 0);
      wr(3'd3, 8'h5A);
      wr(3'd7, 8'hEC);
      chk("R3 cmd ignored", cmd_start, 0);
      rd(3'd7, d); chk("R3 status", d, 16'h00C0);
      check_tf("R3");
      done_pulse();
      chk("R6 irq", irq, 1);
      rd(3'd7, d); chk("R6 done", d, 16'h0040);

      // R7/R10 random DMA rounds
      for (int i = 0; i < 12; i++) begin
         bit is_wr = $urandom % 2;
         irq_disable = ($urandom % 3) == 0;
         for (int a = 2; a <= 6; a++) begin
            logic [7:0] v = 8'($urandom);
            wr(3'(a), v); tf[a] = v;
         end
         wr(3'd7, is_wr ? 8'hCA : 8'hC8);
         chk("R7 start", cmd_start, 1);
         chk("R7 kind", cmd_kind, is_wr ? 2'd3 : 2'd2);
         chk("R7 lba", cmd_lba, {tf[5], tf[4], tf[3]});
         chk("R7 count", cmd_count, tf[2]);
         rd(3'd7, d); chk("R7 busy", d, 16'h00C0);
         wr(3'd4, 8'($urandom));
         chk("R3 lba held", cmd_lba, {tf[5], tf[4], tf[3]});
         repeat ($urandom % 8) @(negedge clk);
         done_pulse();
         chk(irq_disable ? "R10 masked irq" : "R7 irq", irq, !irq_disable);
         rd(3'd7, d); chk("R7 done", d, 16'h0040);
         chk("R9 irq cleared", irq, 0);
      end
      irq_disable = 0;

      // R8 unknown command then recovery
      begin
         logic [7:0] op;
         do op = 8'($urandom); while (op == 8'hC8 || op == 8'hCA || op == 8'hE7 || op == 8'hEC);
         wr(3'd7, op);
         chk("R8 irq", irq, 1);
         chk("R8 no start", cmd_start, 0);
         rd(3'd7, d); chk("R8 status", d, 16'h0041);
         wr(3'd7, 8'hC8);
         rd(3'd7, d); chk("R8 err cleared", d, 16'h00C0);
         done_pulse();
         rd(3'd7, d); chk("R8 done", d, 16'h0040);
      end

      // R11 stray completion
      done_pulse();
      chk("R11 irq", irq, 0);
      rd(3'd7, d); chk("R11 status", d, 16'h0040);

      // R9 status read and completion on one edge
      wr(3'd7, 8'hE7);
      @(negedge clk); bus_addr = 3'd7; bus_rd = 1; ext_done = 1;
      #1 chk("R9 read sees busy", bus_rdata, 16'h00C0);
      @(posedge clk); #1 bus_rd = 0; ext_done = 0;
      chk("R9 raise wins", irq, 1);
      rd(3'd7, d); chk("R9 status", d, 16'h0040);
      chk("R9 cleared later", irq, 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule